// File: doc/BRIEF.md
# Two-Bank Prioritised Interrupt Controller

This block gathers 32 interrupt sources and presents them to a processor as two independent request lines: a normal request and a fast request. Each source first passes through shared conditioning: a per-source polarity bit decides whether the input is inverted, and a per-source hold bit decides whether an asserted input is only sampled or also caught in a latch until software clears it. Every source also carries a 4-bit priority shared by both request lines. A value of 0 is the most urgent.

Each request line has its own register bank. A bank holds an enable mask that is set and cleared by writing ones, a priority threshold, a raw and a masked view of the pending sources, a register that names the current winning source, and an acknowledge location that acts when it is read. Software reads the masked view and keeps fetching the winner until the masked view is zero. Where a source is latched, software reads the acknowledge location to release it. All access goes through a simple synchronous register bus whose read data returns one clock after the read strobe.

Top module: `intc_two_bank`

## Requirements
- R1: After reset both request outputs are low, both enable masks are 0, all hold bits are 0, all polarity bits are 1, all priorities are 0 and both thresholds are 0xF.
- R2: In each bank a write to offset 0x08 sets the mask bits where the write data has ones, and a write to offset 0x0C clears the mask bits where the write data has ones. Zero bits leave the mask unchanged. A read of either offset returns the mask. The normal bank is at 0x000 and the fast bank is at 0x100.
- R3: The raw view (bank offset 0x04) shows a source as pending when its registered input equals its polarity bit, written at 0x200, where 1 means not inverted. A latched source also shows as pending.
- R4: The masked view (bank offset 0x00) is raw & enable & (priority <= threshold). A bank's request output is high exactly when its masked view was nonzero at the previous clock edge. A source input therefore reaches the request output two edges after it is applied.
- R5: The winner register (bank offset 0x20) returns the number of the masked-pending source with the smallest priority value. On equal priority the lower source number wins. It returns 0 when nothing is pending.
- R6: The threshold (bank offset 0x2C, 4 bits) excludes every source whose priority (4 bits at 0x300 + 4*n) is numerically greater than it.
- R7: A source whose hold bit is 1 (bit n at 0x204) stays pending after its input drops. An acknowledge read (bank offset 0x28) clears it only in a bank whose current winner is that source. An acknowledge read in the other bank leaves it pending.
- R8: A source whose hold bit is 0 follows its input directly, and an acknowledge read has no effect on it.
- R9: Read data appears in the cycle after the read strobe and is 0 in every other cycle. Unmapped addresses and the acknowledge location read as 0.
- R10: The two banks keep separate masks and thresholds. A write to one bank changes neither the other bank's state nor its request output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe. The acknowledge location has a side effect on read |
| bus_rdata | output | 32 | Registered read data, valid one cycle after bus_re |
| src_i | input | 32 | Interrupt source inputs, synchronous to clk |
| irq_o | output | 1 | Normal request, registered |
| fiq_o | output | 1 | Fast request, registered |

## Verification
The assertions assume that the sources are already synchronous to the clock and that write and read strobes never come in the same cycle. They also assume that a write hits exactly one register. The stimulus changes sources and strobes only on the falling edge, so every input is stable across the rising edge. Every access goes through single-cycle write or read tasks that never overlap. The hold-bit assertion relies on acknowledge clears coming only from the banks, and the bench issues acknowledge reads both to the bank that owns the latched source and to the bank that does not.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // bank-relative offsets
  localparam logic [7:0] OFF_STAT = 8'h00;
  localparam logic [7:0] OFF_RAW  = 8'h04;
  localparam logic [7:0] OFF_EN   = 8'h08;
  localparam logic [7:0] OFF_DIS  = 8'h0C;
  localparam logic [7:0] OFF_CUR  = 8'h20;
  localparam logic [7:0] OFF_ACK  = 8'h28;
  localparam logic [7:0] OFF_THR  = 8'h2C;
  // shared configuration addresses
  localparam logic [11:0] ADR_POL = 12'h200;
  localparam logic [11:0] ADR_STK = 12'h204;
  localparam logic [11:0] ADR_PRI = 12'h300;
endpackage

// File: rtl/intc_src_cfg.sv
module intc_src_cfg
  import intc_pkg::*;
#(
  parameter int N  = 32,
  parameter int PW = 4,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      addr_i,
  input  logic               we_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [N-1:0]       src_i,
  input  logic [N-1:0]       clr_i,
  output logic [N-1:0]       pend_o,
  output logic [N-1:0][PW-1:0] pri_o,
  output logic [DW-1:0]      rdata_o
);
  logic [N-1:0] src_q, pol_q, stk_q, lat_q, cond, stk_d;
  logic [N-1:0][PW-1:0] pri_q;

  assign cond  = src_q ^ ~pol_q;
  assign stk_d = (we_i && addr_i == AW'(ADR_STK)) ? wdata_i[N-1:0] : stk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      pol_q <= '1;
      stk_q <= '0;
      lat_q <= '0;
    end else begin
      src_q <= src_i;
      stk_q <= stk_d;
      lat_q <= stk_d & ((lat_q & ~clr_i) | cond);
      if (we_i && addr_i == AW'(ADR_POL)) pol_q <= wdata_i[N-1:0];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pri
    always_ff @(posedge clk) begin
      if (rst) pri_q[g] <= '0;
      else if (we_i && addr_i == AW'(ADR_PRI + 4 * g)) pri_q[g] <= wdata_i[PW-1:0];
    end
  end

  assign pend_o = cond | (stk_q & lat_q);
  assign pri_o  = pri_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADR_POL)) rdata_o = DW'(pol_q);
    else if (addr_i == AW'(ADR_STK)) rdata_o = DW'(stk_q);
    else begin
      for (int i = 0; i < N; i++)
        if (addr_i == AW'(ADR_PRI + 4 * i)) rdata_o = DW'(pri_q[i]);
    end
  end

  // R7: a held source not released by a bank remains pending
  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(lat_q & ~clr_i) & stk_q & ~pend_o) == '0));
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int N  = 32,
  parameter int PW = 4,
  parameter int DW = 32,
  localparam int WW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_i,
  input  logic [7:0]         off_i,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [N-1:0]       pend_i,
  input  logic [N-1:0][PW-1:0] pri_i,
  output logic               req_o,
  output logic [N-1:0]       clr_o,
  output logic [DW-1:0]      rdata_o
);
  logic [N-1:0]  en_q, pass, masked;
  logic [PW-1:0] thr_q;
  logic [WW-1:0] win;
  logic [PW-1:0] best;
  logic          found;
  logic          wr, ack;

  assign wr  = we_i && sel_i;
  assign ack = re_i && sel_i && off_i == OFF_ACK;

  for (genvar g = 0; g < N; g++) begin : g_pass
    assign pass[g] = pri_i[g] <= thr_q;
  end
  assign masked = pend_i & en_q & pass;

  always_comb begin
    win   = '0;
    best  = '1;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (masked[i] && (!found || pri_i[i] < best)) begin
        win   = WW'(i);
        best  = pri_i[i];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      thr_q <= '1;
      req_o <= 1'b0;
    end else begin
      req_o <= |masked;
      if (wr && off_i == OFF_EN)  en_q  <= en_q | wdata_i[N-1:0];
      if (wr && off_i == OFF_DIS) en_q  <= en_q & ~wdata_i[N-1:0];
      if (wr && off_i == OFF_THR) thr_q <= wdata_i[PW-1:0];
    end
  end

  assign clr_o = (ack && found) ? ({{(N-1){1'b0}}, 1'b1} << win) : '0;

  always_comb begin
    case (off_i)
      OFF_STAT:       rdata_o = DW'(masked);
      OFF_RAW:        rdata_o = DW'(pend_i);
      OFF_EN, OFF_DIS: rdata_o = DW'(en_q);
      OFF_CUR:        rdata_o = DW'(win);
      OFF_THR:        rdata_o = DW'(thr_q);
      default:        rdata_o = '0;
    endcase
  end

  p_win_pending_r5: assert property (@(posedge clk) disable iff (rst)
    (|masked) |-> masked[win]);
  p_win_thr_r6: assert property (@(posedge clk) disable iff (rst)
    (|masked) |-> (pri_i[win] <= thr_q));
  p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && off_i == OFF_EN) |=> ((en_q & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));
  p_dis_clr_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && off_i == OFF_DIS) |=> ((en_q & $past(wdata_i[N-1:0])) == '0));
endmodule

// File: rtl/intc_two_bank.sv
module intc_two_bank
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  src_i,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int NB = 2;

  logic [N_SRC-1:0]              pend;
  logic [N_SRC-1:0][PRIO_W-1:0]  pri;
  logic [NB-1:0][N_SRC-1:0]      clr_b;
  logic [NB-1:0][DATA_W-1:0]     bank_rd;
  logic [NB-1:0]                 req;
  logic [DATA_W-1:0]             cfg_rd, rd_mux;
  logic                          in_banks;

  assign in_banks = bus_addr[ADDR_W-1:9] == '0;

  intc_src_cfg #(.N(N_SRC), .PW(PRIO_W), .AW(ADDR_W), .DW(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .we_i(bus_we), .wdata_i(bus_wdata),
    .src_i(src_i), .clr_i(clr_b[0] | clr_b[1]), .pend_o(pend), .pri_o(pri),
    .rdata_o(cfg_rd));

  for (genvar b = 0; b < NB; b++) begin : g_bank
    intc_bank #(.N(N_SRC), .PW(PRIO_W), .DW(DATA_W)) u_bank (
      .clk(clk), .rst(rst),
      .sel_i(in_banks && bus_addr[8] == b[0]),
      .off_i(bus_addr[7:0]), .we_i(bus_we), .re_i(bus_re), .wdata_i(bus_wdata),
      .pend_i(pend), .pri_i(pri), .req_o(req[b]), .clr_o(clr_b[b]),
      .rdata_o(bank_rd[b]));
  end

  assign rd_mux = in_banks ? bank_rd[bus_addr[8]] : cfg_rd;

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_re ? rd_mux : '0;
  end

  assign irq_o = req[0];
  assign fiq_o = req[1];
endmodule

// File: tb/tb_intc_two_bank.sv
module tb_intc_two_bank;
  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic [11:0] addr = '0;
  logic we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0, src = '0;
  logic [31:0] rdata;
  logic irq, fiq;

  intc_two_bank dut (.clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_re(re), .bus_rdata(rdata), .src_i(src),
    .irq_o(irq), .fiq_o(fiq));

  int n_run = 0, n_fail = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit [31:0] m_srcq, m_lat, m_pol, m_stk, m_rd;
  bit [31:0] m_en [2];
  bit [3:0]  m_thr [2];
  bit [3:0]  m_pri [32];
  bit        m_req [2];

  function automatic bit [31:0] f_pend();
    bit [31:0] c = ~(m_srcq ^ m_pol);
    return c | (m_stk & m_lat);
  endfunction

  function automatic bit [31:0] f_masked(int b);
    bit [31:0] p = f_pend(), r = '0;
    for (int i = 0; i < 32; i++)
      r[i] = p[i] && m_en[b][i] && (m_pri[i] <= m_thr[b]);
    return r;
  endfunction

  function automatic int f_win(int b, output bit any);
    bit [31:0] m = f_masked(b);
    int w = 0, bp = 99;
    any = 0;
    for (int i = 0; i < 32; i++)
      if (m[i] && int'(m_pri[i]) < bp) begin w = i; bp = m_pri[i]; any = 1; end
    return w;
  endfunction

  function automatic bit [31:0] f_read(bit [11:0] a);
    bit any;
    if (a[11:9] == 0) begin
      int b = a[8];
      case (a[7:0])
        8'h00: return f_masked(b);
        8'h04: return f_pend();
        8'h08, 8'h0C: return m_en[b];
        8'h20: return 32'(f_win(b, any));
        8'h2C: return 32'(m_thr[b]);
        default: return 0;
      endcase
    end
    if (a == 12'h200) return m_pol;
    if (a == 12'h204) return m_stk;
    if (a >= 12'h300 && a < 12'h380 && a[1:0] == 0) return 32'(m_pri[(a - 12'h300) >> 2]);
    return 0;
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_srcq = 0; m_lat = 0; m_pol = '1; m_stk = 0; m_rd = 0;
      for (int b = 0; b < 2; b++) begin m_en[b] = 0; m_thr[b] = 4'hF; m_req[b] = 0; end
      for (int i = 0; i < 32; i++) m_pri[i] = 0;
    end else begin
      bit [31:0] clr = 0, cond = ~(m_srcq ^ m_pol), stk_new;
      bit any;
      bit nreq [2];
      bit [31:0] nrd;
      nrd = re ? f_read(addr) : 0;
      for (int b = 0; b < 2; b++) begin
        int w = f_win(b, any);
        nreq[b] = f_masked(b) != 0;
        if (re && addr == 12'(b * 256 + 'h28) && any) clr[w] = 1;
      end
      stk_new = (we && addr == 12'h204) ? wdata : m_stk;
      m_lat = stk_new & ((m_lat & ~clr) | cond);
      m_stk = stk_new;
      if (we) begin
        if (addr == 12'h200) m_pol = wdata;
        if (addr >= 12'h300 && addr < 12'h380 && addr[1:0] == 0) m_pri[(addr - 12'h300) >> 2] = wdata[3:0];
        for (int b = 0; b < 2; b++) begin
          if (addr == 12'(b * 256 + 'h08)) m_en[b] |= wdata;
          if (addr == 12'(b * 256 + 'h0C)) m_en[b] &= ~wdata;
          if (addr == 12'(b * 256 + 'h2C)) m_thr[b] = wdata[3:0];
        end
      end
      m_req[0] = nreq[0]; m_req[1] = nreq[1];
      m_rd = nrd;
      m_srcq = src;
    end
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one clock: model and DUT both update at the edge, compared afterwards
  task automatic cycle();
    @(posedge clk);
    model_edge();
    #2;
    chk("R4 irq", 32'(irq), 32'(m_req[0]));
    chk("R10 fiq", 32'(fiq), 32'(m_req[1]));
    chk({cur_req, " rdata"}, rdata, m_rd);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(bit [11:0] a, bit [31:0] d);
    addr = a; wdata = d; we = 1; cycle(); we = 0; wdata = 0;
  endtask

  task automatic rd(bit [11:0] a);
    addr = a; re = 1; cycle(); re = 0;
  endtask

  task automatic expect_read(bit [11:0] a, bit [31:0] exp, string req);
    rd(a);
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    idle(3);
    rst = 0;
    idle(1);
    // R1 reset state
    cur_req = "R1";
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fiq", 32'(fiq), 0);
    expect_read(12'h200, 32'hFFFF_FFFF, "R1 polarity");
    expect_read(12'h204, 0, "R1 hold");
    expect_read(12'h02C, 32'hF, "R1 thr irq");
    expect_read(12'h12C, 32'hF, "R1 thr fiq");
    expect_read(12'h008, 0, "R1 mask");
    expect_read(12'h304, 0, "R1 prio");

    // R2 write-one set/clear
    cur_req = "R2";
    wr(12'h008, 32'h0000_00F0);
    wr(12'h00C, 32'h0000_0030);
    expect_read(12'h008, 32'h0000_00C0, "R2 en read");
    expect_read(12'h00C, 32'h0000_00C0, "R2 dis read");
    // R10 other bank independent
    cur_req = "R10";
    wr(12'h108, 32'h1);
    expect_read(12'h108, 32'h1, "R10 fiq mask");
    expect_read(12'h008, 32'h0000_00C0, "R10 irq mask kept");

    // R3 raw view and polarity
    cur_req = "R3";
    src = 32'h81; idle(2);
    expect_read(12'h004, 32'h81, "R3 raw");
    expect_read(12'h104, 32'h81, "R3 raw fiq");
    wr(12'h200, 32'hFFFF_FFFE);
    expect_read(12'h004, 32'h80, "R3 inverted high");
    src = 32'h80; idle(1);
    expect_read(12'h004, 32'h81, "R3 inverted low");
    wr(12'h200, 32'hFFFF_FFFF);
    src = 0; idle(2);

    // R4 request outputs
    cur_req = "R4";
    src = 32'h40; idle(3);
    chk("R4 irq high", 32'(irq), 1);
    chk("R10 fiq low", 32'(fiq), 0);
    expect_read(12'h000, 32'h40, "R4 masked");
    src = 32'h01; idle(3);
    chk("R4 irq low", 32'(irq), 0);
    chk("R10 fiq high", 32'(fiq), 1);
    src = 0; idle(2);

    // R5 winner selection
    cur_req = "R5";
    wr(12'h318, 3); wr(12'h31C, 2);
    src = 32'hC0; idle(2);
    expect_read(12'h020, 7, "R5 lower value wins");
    wr(12'h31C, 3);
    expect_read(12'h020, 6, "R5 tie lower index");
    src = 0; idle(1);
    expect_read(12'h020, 0, "R5 none");
    src = 32'hC0; idle(1);

    // R6 threshold
    cur_req = "R6";
    wr(12'h02C, 2); idle(2);
    expect_read(12'h000, 0, "R6 excluded");
    chk("R6 irq low", 32'(irq), 0);
    wr(12'h318, 2); idle(2);
    expect_read(12'h000, 32'h40, "R6 equal passes");
    expect_read(12'h020, 6, "R6 winner");
    wr(12'h02C, 32'hF);
    src = 0; wr(12'h318, 0); wr(12'h31C, 0);

    // R7 latched sources
    cur_req = "R7";
    wr(12'h204, 32'h20);
    wr(12'h008, 32'h20);
    wr(12'h10C, 32'hFFFF_FFFF);
    wr(12'h108, 32'h200);
    src = 32'h20; cycle();
    src = 32'h200; idle(3);
    expect_read(12'h004, 32'h220, "R7 latched raw");
    expect_read(12'h000, 32'h20, "R7 held");
    rd(12'h128);
    chk("R9 ack reads zero", rdata, 0);
    idle(1);
    expect_read(12'h000, 32'h20, "R7 other bank ack");
    rd(12'h028); idle(1);
    expect_read(12'h000, 0, "R7 released");
    idle(1);
    chk("R7 irq low", 32'(irq), 0);

    // R8 level sources ignore acknowledge
    cur_req = "R8";
    src = 32'h240; idle(2);
    rd(12'h028); idle(1);
    expect_read(12'h000, 32'h40, "R8 ack no effect");
    src = 32'h200; idle(1);
    expect_read(12'h000, 0, "R8 follows input");

    // R9 unmapped
    cur_req = "R9";
    expect_read(12'h010, 0, "R9 bank hole");
    expect_read(12'h208, 0, "R9 cfg hole");
    expect_read(12'h380, 0, "R9 past prio");
    idle(1);
    chk("R9 idle zero", rdata, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule